// File: doc/BRIEF.md
# Buffer-Flag Interrupt Pin Multiplexer

This block owns two bits of a general-purpose output port. Out of reset both bits are plain port pins that drive whatever the firmware last wrote into port bit positions 4 and 5. A one-cycle enable-flags strobe switches the pair into flag mode, and the block can then interrupt a host. In flag mode the pin at bit 4 shows output-buffer-full, which tells the host that data is waiting. The pin at bit 5 shows the inverse of input-buffer-full, which tells the host that the slave can accept a byte.

Once flag mode is on, a port write no longer sets the pin level. Bit 4 and bit 5 of the written byte become per-pin enables. A 1 passes the flag through, and a 0 holds the pin low. The latch is the same register in both modes, so the value written before the switch becomes the enable state at the moment of the switch. Flag mode stays on until reset. The port and flag inputs are sampled on the rising clock edge. Each pin is a combinational function of the registered state and the live flag inputs.

Top module: `bflag_pin_mux`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in port mode and every latch bit is 1. Both pins are therefore high.
- R2: In port mode, the bit-4 pin equals latch bit 4 and the bit-5 pin equals latch bit 5, whatever the values of obf_i and ibf_i.
- R3: A port write loads port_data_i into the latch at the clock edge where port_wr_i is 1, and the pins show the new value after that edge. With no write, the latch keeps its value.
- R4: An enable-flags strobe switches the block to flag mode at the clock edge where it is sampled.
- R5: In flag mode with latch bit 4 = 1, the bit-4 pin follows obf_i.
- R6: In flag mode with latch bit 4 = 0, the bit-4 pin is low.
- R7: In flag mode with latch bit 5 = 1, the bit-5 pin equals the inverse of ibf_i.
- R8: In flag mode with latch bit 5 = 0, the bit-5 pin is low.
- R9: Flag mode lasts until reset. Port writes do not leave it, and a repeated enable-flags strobe changes nothing.
- R10: Latch bits other than 4 and 5 have no effect on either pin.
- R11: When a port write and an enable-flags strobe fall on the same edge, both take effect, and the newly written bits act as enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| obf_i | input | 1 | Output-buffer-full status flag |
| ibf_i | input | 1 | Input-buffer-full status flag |
| port_wr_i | input | 1 | Port write strobe, one cycle |
| port_data_i | input | 8 | Byte written to the port |
| en_flags_i | input | 1 | Enable-flags strobe, one cycle |
| obf_pin_o | output | 1 | Pin at port bit 4 |
| ibf_pin_o | output | 1 | Pin at port bit 5 |

## Verification
The assertions check several rules on every cycle: the latch load and hold, entry into flag mode and its persistence, port-mode pass-through, and the forced-low level of a disabled pin. The bench scenarios cover the rest. They show that live flag changes reach an enabled pin in both polarities, and that the other port bits have no effect. They also cover a write and an enable-flags strobe on the same edge, a repeated enable-flags strobe, and a reset in the middle of flag mode that returns the pins to port behaviour.

// File: rtl/bflag_pkg.sv
package bflag_pkg;
  typedef enum logic {
    PM_PORT = 1'b0,
    PM_FLAG = 1'b1
  } pin_mode_e;

  localparam int unsigned NUM_PINS = 2;
endpackage

// File: rtl/bflag_mode_reg.sv
module bflag_mode_reg
  import bflag_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_flags_i,
  output pin_mode_e mode_o
);
  pin_mode_e mode_q;

  // sticky until reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q <= PM_PORT;
    else if (en_flags_i) mode_q <= PM_FLAG;
  end

  assign mode_o = mode_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == PM_FLAG) |=> (mode_q == PM_FLAG));
endmodule

// File: rtl/bflag_port_latch.sv
module bflag_port_latch #(
  parameter int unsigned     WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (wr_i) q <= data_i;
  end

  assign q_o = q;
endmodule

// File: rtl/bflag_pin_drv.sv
module bflag_pin_drv
  import bflag_pkg::*;
#(
  parameter bit INVERT = 1'b0
) (
  input  pin_mode_e mode_i,
  input  logic      latch_i,
  input  logic      flag_i,
  output logic      pin_o
);
  logic flag_lvl;

  assign flag_lvl = INVERT ? ~flag_i : flag_i;

  // in flag mode the latched bit is an enable, else it is the level
  always_comb begin
    unique case (mode_i)
      PM_FLAG: pin_o = latch_i & flag_lvl;
      default: pin_o = latch_i;
    endcase
  end
endmodule

// File: rtl/bflag_pin_mux.sv
module bflag_pin_mux
  import bflag_pkg::*;
#(
  parameter int unsigned PORT_W  = 8,
  parameter int unsigned OBF_BIT = 4,
  parameter int unsigned IBF_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              obf_i,
  input  logic              ibf_i,
  input  logic              port_wr_i,
  input  logic [PORT_W-1:0] port_data_i,
  input  logic              en_flags_i,
  output logic              obf_pin_o,
  output logic              ibf_pin_o
);
  localparam logic [PORT_W-1:0] LATCH_RST = '1;

  pin_mode_e         mode;
  logic [PORT_W-1:0] latch_q;
  logic [NUM_PINS-1:0] pins;
  logic [NUM_PINS-1:0] flags;
  logic [NUM_PINS-1:0] en_bits;

  bflag_mode_reg u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_flags_i (en_flags_i),
    .mode_o     (mode)
  );

  bflag_port_latch #(
    .WIDTH   (PORT_W),
    .RST_VAL (LATCH_RST)
  ) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (port_wr_i),
    .data_i (port_data_i),
    .q_o    (latch_q)
  );

  // index 0 -> OBF pin (true polarity), index 1 -> IBF pin (inverted)
  assign flags   = {ibf_i, obf_i};
  assign en_bits = {latch_q[IBF_BIT], latch_q[OBF_BIT]};

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    bflag_pin_drv #(
      .INVERT (g == 1)
    ) u_drv (
      .mode_i  (mode),
      .latch_i (en_bits[g]),
      .flag_i  (flags[g]),
      .pin_o   (pins[g])
    );
  end

  assign obf_pin_o = pins[0];
  assign ibf_pin_o = pins[1];

  // R3
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_wr_i |=> (latch_q == $past(port_data_i)));
  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_wr_i |=> $stable(latch_q));
  // R4
  flag_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_flags_i |=> (mode == PM_FLAG));
  // R2
  port_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PM_PORT) |-> (obf_pin_o == latch_q[OBF_BIT] && ibf_pin_o == latch_q[IBF_BIT]));
  // R6
  obf_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PM_FLAG && !latch_q[OBF_BIT]) |-> !obf_pin_o);
  // R8
  ibf_off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PM_FLAG && !latch_q[IBF_BIT]) |-> !ibf_pin_o);
endmodule

// File: tb/bflag_pin_mux_tb.sv
module bflag_pin_mux_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       obf_i = 1'b0;
  logic       ibf_i = 1'b0;
  logic       port_wr_i = 1'b0;
  logic [7:0] port_data_i = '0;
  logic       en_flags_i = 1'b0;
  logic       obf_pin_o;
  logic       ibf_pin_o;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk_i = ~clk_i;

  bflag_pin_mux u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .obf_i       (obf_i),
    .ibf_i       (ibf_i),
    .port_wr_i   (port_wr_i),
    .port_data_i (port_data_i),
    .en_flags_i  (en_flags_i),
    .obf_pin_o   (obf_pin_o),
    .ibf_pin_o   (ibf_pin_o)
  );

  // {wr, en, data[7:0], obf, ibf, exp_obf_pin, exp_ibf_pin}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 flags ignored
    {1'b1, 1'b0, 8'h30, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
    {1'b1, 1'b0, 8'hCF, 1'b1, 1'b0, 1'b0, 1'b0}, // R10
    {1'b0, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 hold
    {1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 load
    {1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0}, // R4 enter flag mode
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0}, // R5
    {1'b1, 1'b0, 8'h30, 1'b1, 1'b0, 1'b1, 1'b1}, // R7
    {1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0}, // R5
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}, // R7
    {1'b1, 1'b0, 8'h20, 1'b1, 1'b0, 1'b0, 1'b1}, // R6
    {1'b1, 1'b0, 8'hDF, 1'b1, 1'b0, 1'b1, 1'b0}, // R8
    {1'b1, 1'b1, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0}, // R9 repeat strobe
    {1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1}  // R9
  };

  function automatic string req_of(int i);
    case (i)
      0, 1:   return "R2";
      2:      return "R10";
      3, 4:   return "R3";
      5:      return "R4";
      6, 8:   return "R5";
      7, 9:   return "R7";
      10:     return "R6";
      11:     return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic exp_o, logic exp_i);
    n_run++;
    if (obf_pin_o !== exp_o || ibf_pin_o !== exp_i) begin
      n_fail++;
      $display("FAIL %s: pins obf=%b ibf=%b, expected obf=%b ibf=%b",
               req, obf_pin_o, ibf_pin_o, exp_o, exp_i);
    end
  endtask

  task automatic step(logic wr, logic en, logic [7:0] d, logic ob, logic ib);
    @(negedge clk_i);
    port_wr_i = wr; en_flags_i = en; port_data_i = d; obf_i = ob; ibf_i = ib;
    @(posedge clk_i);
    #1;
    port_wr_i = 1'b0; en_flags_i = 1'b0;
  endtask

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 2000) begin
      n_fail++;
      $display("FAIL watchdog: cycles=%0d, expected < 2000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    obf_i = 1'b0; ibf_i = 1'b1;
    #12;
    check("R1", 1'b1, 1'b1); // in reset: port mode, latch all ones
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R1", 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11:4], VEC[i][3], VEC[i][2]);
      check(req_of(i), VEC[i][1], VEC[i][0]);
    end

    // R1: reset in flag mode returns to port mode with latch ones
    @(negedge clk_i); rst_ni = 1'b0; obf_i = 1'b0; ibf_i = 1'b1;
    #1 check("R1", 1'b1, 1'b1);
    @(negedge clk_i); rst_ni = 1'b1;
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
    check("R1", 1'b1, 1'b1);

    // R11: write and enable on the same edge
    step(1'b1, 1'b1, 8'h20, 1'b1, 1'b0);
    check("R11", 1'b0, 1'b1);
    @(negedge clk_i); obf_i = 1'b1; ibf_i = 1'b1;
    #1 check("R11", 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule